// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects reset requests from five sources and holds the rest of the system in reset until a timed release. The sources are a power-on pulse, a watchdog timeout, an illegal instruction decode (which also covers a STOP instruction issued while stopping is not allowed), an opcode fetch from an address that the memory map does not decode, and a reset vector byte that reads back as all ones (erased). The block drives an active-low reset line and keeps a small status word with one sticky flag per cause. Once an erased vector has been seen, it raises a flag that tells the rest of the chip to enter monitor mode.

A power-on pulse starts a long recovery of 4096 clock cycles, followed by a further 32 cycles. Every other cause gives a short reset of 32 cycles. Requests that arrive while the reset line is low are dropped. A new power-on pulse is the exception: it always restarts the full recovery. The CPU and the address decoder sit outside this block. They supply the fetch strobe, the opcode qualifier, the address, the read data, the mapped flag and the instruction decodes.

Top module: `rsq_reset_seq`

## Requirements
- R1: After the last cycle in which `por_pulse` is sampled high, `rst_n` stays low for exactly 4096 + 32 = 4128 clock cycles. During and after this reset `status` reads 0x01 (bit 0 = power-on) and `mon_force` is 0.
- R2: A non-power-on cause sampled while `rst_n` is high drives `rst_n` low from the next cycle for exactly 32 cycles. In that same cycle the `status` word is replaced by that cause's flags alone.
- R3: A `wdt_expire` pulse causes an R2 reset with `status` = 0x02 (bit 1 = watchdog).
- R4: A `bad_opcode` pulse causes an R2 reset with `status` = 0x04 (bit 2 = illegal instruction).
- R5: A `stop_decode` pulse with `stop_allow` = 0 acts exactly like R4 (`status` = 0x04). With `stop_allow` = 1 it has no effect.
- R6: A fetch (`fetch_vld` = 1) with `fetch_op` = 1 and `addr_mapped` = 0 causes an R2 reset with `status` = 0x08 (bit 3 = bad fetch address). The same fetch with `fetch_op` = 0 (a data read) has no effect.
- R7: A fetch from 0xFFFE or 0xFFFF that returns `rdata` = 0xFF causes an R2 reset with `status` = 0x10 (bit 4 = erased vector) and sets `mon_force`. `mon_force` stays at 1 through later non-power-on resets and is cleared only by power-on. A read of 0xFF from any other address has no effect.
- R8: Several causes sampled in the same cycle set all of their flags together and start a single 32-cycle reset.
- R9: Non-power-on requests sampled while `rst_n` is low are ignored. They change neither `status`, `mon_force` nor the length of the reset in progress.
- R10: A power-on pulse during any reset restarts the full R1 recovery, counted from the last cycle of the pulse, and sets `status` to 0x01 and `mon_force` to 0.
- R11: `status` and `mon_force` hold their values indefinitely while no new cause is accepted. Observing them never clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_pulse | input | 1 | Power-on request, active high, synchronous |
| wdt_expire | input | 1 | Watchdog timeout request |
| fetch_vld | input | 1 | CPU bus read strobe |
| fetch_op | input | 1 | Current read is an opcode fetch |
| addr | input | 16 | CPU address bus |
| addr_mapped | input | 1 | Address decoder hit for `addr` |
| rdata | input | 8 | Read data bus |
| bad_opcode | input | 1 | Illegal instruction decoded |
| stop_decode | input | 1 | STOP instruction decoded |
| stop_allow | input | 1 | Configuration bit: STOP permitted |
| rst_n | output | 1 | System reset, active low |
| mon_force | output | 1 | Force monitor mode after erased-vector reset |
| status | output | 8 | Sticky reset cause flags, bits 4..0 |

## Verification
On every cycle, the assertions check the following. An accepted cause pulls `rst_n` low on the next cycle. The power-on flag never shares the status word with another flag. The status word is frozen whenever no cause is accepted, which covers the requests dropped during reset. The monitor flag never falls outside power-on. The exact reset lengths of 4128 and 32 cycles, the per-cause flag encodings, the stop-enable and data-read exemptions, and the restart of recovery by a power-on pulse in mid-reset can only be shown by the bench's scenarios. The bench measures each low interval of `rst_n` against a queue of expected results.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_POR  = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    localparam int NCAUSE  = 5;
    localparam int CZ_POR  = 0;
    localparam int CZ_WDT  = 1;
    localparam int CZ_IOP  = 2;
    localparam int CZ_IADR = 3;
    localparam int CZ_VEC  = 4;

    typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/rsq_cause_detect.sv
module rsq_cause_detect
    import rsq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          VEC_BYTES = 2,
    parameter logic [15:0] VEC_BASE  = 16'hFFFE
) (
    input  logic              wdt_expire,
    input  logic              fetch_vld,
    input  logic              fetch_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_mapped,
    input  logic [DATA_W-1:0] rdata,
    input  logic              bad_opcode,
    input  logic              stop_decode,
    input  logic              stop_allow,
    output cause_t            cause
);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    logic [VEC_BYTES-1:0] vec_hit;

    // one comparator per vector byte address
    for (genvar i = 0; i < VEC_BYTES; i++) begin : g_vec
        assign vec_hit[i] = (addr == ADDR_W'(VEC_BASE + 16'(i)));
    end

    always_comb begin
        cause          = '0;
        cause[CZ_WDT]  = wdt_expire;
        cause[CZ_IOP]  = bad_opcode | (stop_decode & ~stop_allow);
        cause[CZ_IADR] = fetch_vld & fetch_op & ~addr_mapped;
        cause[CZ_VEC]  = fetch_vld & (|vec_hit) & (rdata == ERASED);
    end
endmodule

// File: rtl/rsq_phase_timer.sv
module rsq_phase_timer
    import rsq_pkg::*;
#(
    parameter int POR_CYC  = 4096,
    parameter int TAIL_CYC = 32
) (
    input  logic clk,
    input  logic por_i,
    input  logic trig_i,
    output logic rst_n_o,
    output logic in_run_o
);
    localparam int MAXC  = (POR_CYC > TAIL_CYC) ? POR_CYC : TAIL_CYC;
    localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (por_i) begin
            tmr_d.ph  = PH_POR;
            tmr_d.cnt = '0;
        end else begin
            unique case (tmr_q.ph)
                PH_POR: begin
                    if (tmr_q.cnt == POR_LAST) begin
                        tmr_d.ph  = PH_TAIL;
                        tmr_d.cnt = '0;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (tmr_q.cnt == TAIL_LAST) begin
                        tmr_d.ph  = PH_RUN;
                        tmr_d.cnt = '0;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (trig_i) begin
                        tmr_d.ph  = PH_TAIL;
                        tmr_d.cnt = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign in_run_o = (tmr_q.ph == PH_RUN);
    assign rst_n_o  = in_run_o;

    // R2
    trig_rst_chk: assert property (@(posedge clk) disable iff (por_i)
        trig_i |=> !rst_n_o);

    // R1
    por_low_chk: assert property (@(posedge clk)
        por_i |=> !rst_n_o);
endmodule

// File: rtl/rsq_status_reg.sv
module rsq_status_reg
    import rsq_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              take_i,
    input  cause_t            cause_i,
    output logic [STAT_W-1:0] status_o,
    output logic              mon_o
);
    typedef struct packed {
        cause_t flags;
        logic   mon;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i) begin
            st_d.flags         = '0;
            st_d.flags[CZ_POR] = 1'b1;
            st_d.mon           = 1'b0;
        end else if (take_i) begin
            st_d.flags         = cause_i;
            st_d.flags[CZ_POR] = 1'b0;
            if (cause_i[CZ_VEC]) begin
                st_d.mon = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign status_o = STAT_W'(st_q.flags);
    assign mon_o    = st_q.mon;

    // R9, R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (por_i)
        !take_i |=> $stable(status_o) && $stable(mon_o));

    // R1
    por_alone_chk: assert property (@(posedge clk) disable iff (por_i)
        status_o[CZ_POR] |-> (status_o[NCAUSE-1:1] == '0));

    // R7
    mon_sticky_chk: assert property (@(posedge clk) disable iff (por_i)
        mon_o |=> mon_o);
endmodule

// File: rtl/rsq_reset_seq.sv
module rsq_reset_seq
    import rsq_pkg::*;
#(
    parameter int          POR_CYC   = 4096,
    parameter int          TAIL_CYC  = 32,
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          STAT_W    = 8,
    parameter int          VEC_BYTES = 2,
    parameter logic [15:0] VEC_BASE  = 16'hFFFE
) (
    input  logic              clk,
    input  logic              por_pulse,
    input  logic              wdt_expire,
    input  logic              fetch_vld,
    input  logic              fetch_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_mapped,
    input  logic [DATA_W-1:0] rdata,
    input  logic              bad_opcode,
    input  logic              stop_decode,
    input  logic              stop_allow,
    output logic              rst_n,
    output logic              mon_force,
    output logic [STAT_W-1:0] status
);
    cause_t cause;
    logic   in_run;
    logic   take;

    rsq_cause_detect #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_BYTES(VEC_BYTES),
        .VEC_BASE (VEC_BASE)
    ) u_detect (
        .wdt_expire (wdt_expire),
        .fetch_vld  (fetch_vld),
        .fetch_op   (fetch_op),
        .addr       (addr),
        .addr_mapped(addr_mapped),
        .rdata      (rdata),
        .bad_opcode (bad_opcode),
        .stop_decode(stop_decode),
        .stop_allow (stop_allow),
        .cause      (cause)
    );

    // a cause is accepted only while the system is running
    assign take = in_run & (|cause);

    rsq_phase_timer #(
        .POR_CYC (POR_CYC),
        .TAIL_CYC(TAIL_CYC)
    ) u_timer (
        .clk     (clk),
        .por_i   (por_pulse),
        .trig_i  (take),
        .rst_n_o (rst_n),
        .in_run_o(in_run)
    );

    rsq_status_reg #(
        .STAT_W(STAT_W)
    ) u_status (
        .clk     (clk),
        .por_i   (por_pulse),
        .take_i  (take),
        .cause_i (cause),
        .status_o(status),
        .mon_o   (mon_force)
    );

    // R8
    single_seq_chk: assert property (@(posedge clk) disable iff (por_pulse)
        take |=> !take);
endmodule

// File: tb/sim_rsq_reset_seq.sv
module sim_rsq_reset_seq;
    localparam int POR_LEN  = 4096 + 32;
    localparam int TAIL_LEN = 32;

    typedef struct {
        string      tag;
        int         len;
        logic [7:0] st;
        logic       mon;
    } exp_t;

    logic        clk = 1'b0;
    logic        por_pulse = 1'b1;
    logic        wdt_expire = 1'b0;
    logic        fetch_vld = 1'b0;
    logic        fetch_op = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        addr_mapped = 1'b1;
    logic [7:0]  rdata = 8'h00;
    logic        bad_opcode = 1'b0;
    logic        stop_decode = 1'b0;
    logic        stop_allow = 1'b1;
    logic        rst_n;
    logic        mon_force;
    logic [7:0]  status;

    int   n_chk = 0;
    int   n_err = 0;
    int   low_cnt = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    rsq_reset_seq u0 (
        .clk        (clk),
        .por_pulse  (por_pulse),
        .wdt_expire (wdt_expire),
        .fetch_vld  (fetch_vld),
        .fetch_op   (fetch_op),
        .addr       (addr),
        .addr_mapped(addr_mapped),
        .rdata      (rdata),
        .bad_opcode (bad_opcode),
        .stop_decode(stop_decode),
        .stop_allow (stop_allow),
        .rst_n      (rst_n),
        .mon_force  (mon_force),
        .status     (status)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: measures each low interval of rst_n and compares with the queue
    always @(negedge clk) begin
        if (por_pulse) begin
            low_cnt = 0;
        end else if (!rst_n) begin
            low_cnt++;
        end else if (low_cnt > 0) begin
            if (sb_q.size() == 0) begin
                check("unexpected reset", low_cnt, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " length"}, low_cnt, e.len);
                check({e.tag, " status"}, int'(status), int'(e.st));
                check({e.tag, " mon_force"}, int'(mon_force), int'(e.mon));
            end
            low_cnt = 0;
        end
    end

    task automatic push(input string tag, input int len, input logic [7:0] st, input logic mon);
        exp_t e;
        e.tag = tag; e.len = len; e.st = st; e.mon = mon;
        sb_q.push_back(e);
    endtask

    task automatic fire(input logic w, input logic iop, input logic stp, input logic sa,
                        input logic fv, input logic fo, input logic [15:0] a,
                        input logic m, input logic [7:0] d);
        @(posedge clk); #2;
        wdt_expire = w; bad_opcode = iop; stop_decode = stp; stop_allow = sa;
        fetch_vld = fv; fetch_op = fo; addr = a; addr_mapped = m; rdata = d;
        @(posedge clk); #2;
        wdt_expire = 1'b0; bad_opcode = 1'b0; stop_decode = 1'b0; stop_allow = 1'b1;
        fetch_vld = 1'b0; fetch_op = 1'b0; addr = 16'h0000; addr_mapped = 1'b1; rdata = 8'h00;
    endtask

    task automatic wait_run;
        do @(negedge clk); while (!rst_n);
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet(input string tag, input logic [7:0] st, input logic mon);
        repeat (40) @(negedge clk);
        check({tag, " rst_n stays high"}, int'(rst_n), 1);
        check({tag, " status unchanged"}, int'(status), int'(st));
        check({tag, " mon_force unchanged"}, int'(mon_force), int'(mon));
    endtask

    initial begin
        push("R1 power-on", POR_LEN, 8'h01, 1'b0);
        repeat (3) @(posedge clk);
        #2 por_pulse = 1'b0;
        @(negedge clk);
        check("R1 reset state rst_n", int'(rst_n), 0);
        check("R1 reset state status", int'(status), 8'h01);
        wait_run();

        push("R2/R3 watchdog", TAIL_LEN, 8'h02, 1'b0);
        fire(1, 0, 0, 1, 0, 0, 16'h0000, 1, 8'h00);
        wait_run();

        fire(0, 0, 1, 1, 0, 0, 16'h0000, 1, 8'h00);
        quiet("R5 STOP allowed", 8'h02, 1'b0);

        push("R4 illegal opcode", TAIL_LEN, 8'h04, 1'b0);
        fire(0, 1, 0, 1, 0, 0, 16'h0000, 1, 8'h00);
        wait_run();

        fire(0, 0, 0, 1, 1, 0, 16'h0300, 0, 8'h00);
        quiet("R6 unmapped data read", 8'h04, 1'b0);

        push("R5 STOP disabled", TAIL_LEN, 8'h04, 1'b0);
        fire(0, 0, 1, 0, 0, 0, 16'h0000, 1, 8'h00);
        wait_run();

        push("R6 unmapped opcode fetch", TAIL_LEN, 8'h08, 1'b0);
        fire(0, 0, 0, 1, 1, 1, 16'h0300, 0, 8'h00);
        wait_run();

        fire(0, 0, 0, 1, 1, 0, 16'h1234, 1, 8'hFF);
        quiet("R7 0xFF off vector", 8'h08, 1'b0);
        quiet("R11 status held", 8'h08, 1'b0);

        push("R7 erased vector FFFF", TAIL_LEN, 8'h10, 1'b1);
        fire(0, 0, 0, 1, 1, 0, 16'hFFFF, 1, 8'hFF);
        wait_run();

        push("R7 mon sticky over watchdog", TAIL_LEN, 8'h02, 1'b1);
        fire(1, 0, 0, 1, 0, 0, 16'h0000, 1, 8'h00);
        wait_run();

        push("R8 simultaneous causes", TAIL_LEN, 8'h0E, 1'b1);
        fire(1, 1, 0, 1, 1, 1, 16'h0400, 0, 8'h00);
        wait_run();

        push("R9 ignored during reset", TAIL_LEN, 8'h02, 1'b1);
        fire(1, 0, 0, 1, 0, 0, 16'h0000, 1, 8'h00);
        repeat (4) @(posedge clk);
        fire(0, 1, 0, 1, 0, 0, 16'h0000, 1, 8'h00);
        fire(0, 0, 0, 1, 1, 0, 16'hFFFE, 1, 8'hFF);
        wait_run();

        push("R7 erased vector FFFE", TAIL_LEN, 8'h10, 1'b1);
        fire(0, 0, 0, 1, 1, 0, 16'hFFFE, 1, 8'hFF);
        wait_run();

        push("R10 power-on restart", POR_LEN, 8'h01, 1'b0);
        fire(1, 0, 0, 1, 0, 0, 16'h0000, 1, 8'h00);
        repeat (9) @(posedge clk);
        #2 por_pulse = 1'b1;
        @(posedge clk); #2 por_pulse = 1'b0;
        wait_run();

        check("R1/R7 queue drained", sb_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule